// File: doc/BRIEF.md
# Symbol-Count Parity Tracker

This block watches a stream of 2-bit symbols drawn from a three-letter alphabet {a, b, c}. It keeps two parity bits in a 2-bit state register. One bit tells whether an odd or even number of a symbols has been accepted since reset. The other tells the same for b symbols. A single output bit is high exactly when the a-count is even and the b-count is odd. The output is a pure function of the registered state (a Moore machine), so it never ripples combinationally from the symbol input.

A symbol is taken only in cycles where the valid input is high. When valid is low, the state holds. The unused code 11 does not change the state; instead it raises a one-cycle error pulse in the following cycle. A synchronous reset returns the machine to the all-even state.

Top module: `sym_parity_tracker`

## Requirements
- R1: While rst is high at a rising edge, the state goes to even-a/even-b, and after that edge both matchOut and badSym are 0.
- R2: Symbol codes are a = 2'b00, b = 2'b01, c = 2'b10; code 2'b11 is illegal.
- R3: An accepted a symbol (symValid high, symIn 2'b00) toggles the a-parity and leaves the b-parity unchanged.
- R4: An accepted b symbol (symValid high, symIn 2'b01) toggles the b-parity and leaves the a-parity unchanged.
- R5: An accepted c symbol (symValid high, symIn 2'b10) leaves both parities unchanged.
- R6: When symValid is low, both parities hold, whatever value symIn carries.
- R7: An accepted illegal code (symValid high, symIn 2'b11) leaves both parities unchanged, and badSym is high for exactly the one cycle after that edge. badSym is low after every other edge.
- R8: matchOut is 1 exactly when the registered a-parity is even and the registered b-parity is odd, and it changes in the cycle after the edge that accepted the symbol.
- R9: Reset has priority over a valid symbol presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| symIn | input | 2 | Encoded symbol: a=00, b=01, c=10, 11 illegal |
| symValid | input | 1 | Symbol qualifier; the symbol is taken when high |
| matchOut | output | 1 | High when a-count is even and b-count is odd |
| badSym | output | 1 | One-cycle pulse after an accepted illegal code |

## Verification
The hardest case to reach is an illegal code that arrives in the same cycle as reset, or right after an idle cycle that carries a non-c symbol on symIn. Either one can hide a wrong hold or an error pulse that leaks through. Directed sequences set up these collisions on purpose: reset with each code present, valid low with a and b on the bus, and back-to-back illegal codes. A long pseudo-random phase then mixes valid gaps, all four codes and sparse resets. The reference model uses integer counters for a and b and compares against them every cycle.

// File: rtl/sym_parity_pkg.sv
package sym_parity_pkg;
  localparam int SYM_W = 2;
  localparam int ST_W  = 2;

  typedef enum logic [SYM_W-1:0] {
    SYM_A   = 2'b00,
    SYM_B   = 2'b01,
    SYM_C   = 2'b10,
    SYM_BAD = 2'b11
  } sym_e;

  // Fixed state encoding: bit1 = a-parity, bit0 = a-parity xor b-parity
  typedef enum logic [ST_W-1:0] {
    ST_EA_EB = 2'b00,
    ST_EA_OB = 2'b01,
    ST_OA_OB = 2'b10,
    ST_OA_EB = 2'b11
  } state_e;

  typedef struct packed {
    logic flipA;
    logic flipB;
    logic badCode;
  } strobe_t;
endpackage

// File: rtl/parity_ctrl.sv
module parity_ctrl
  import sym_parity_pkg::*;
(
  input  logic [SYM_W-1:0] symIn,
  input  logic             symValid,
  output strobe_t          strobes
);
  sym_e symCode;

  always_comb begin
    symCode = sym_e'(symIn);
    strobes = '0;
    if (symValid) begin
      unique case (symCode)
        SYM_A:   strobes.flipA   = 1'b1;
        SYM_B:   strobes.flipB   = 1'b1;
        SYM_C:   ;
        SYM_BAD: strobes.badCode = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/parity_state.sv
module parity_state
  import sym_parity_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t strobes,
  output logic    matchOut,
  output logic    badSym
);
  state_e stateQ;
  state_e stateD;

  // a flips both bits (00<->11, 01<->10); b flips bit0 only (00<->01, 10<->11)
  always_comb begin
    stateD = state_e'({stateQ[1] ^ strobes.flipA,
                       stateQ[0] ^ strobes.flipA ^ strobes.flipB});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_EA_EB;
      badSym <= 1'b0;
    end else begin
      stateQ <= stateD;
      badSym <= strobes.badCode;
    end
  end

  assign matchOut = (stateQ == ST_EA_OB);

  // R1 / R9: reset wins and clears state and error flag
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (stateQ == ST_EA_EB && !badSym));

  // R3: a toggles both encoded bits
  a_r3_a_toggles: assert property (@(posedge clk) disable iff (rst)
    strobes.flipA |=> (stateQ == state_e'(~$past(stateQ))));

  // R4: b toggles only bit0
  a_r4_b_toggles: assert property (@(posedge clk) disable iff (rst)
    strobes.flipB |=> (stateQ[1] == $past(stateQ[1]) && stateQ[0] != $past(stateQ[0])));

  // R5 / R6 / R7: no flip strobe means the state holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !(strobes.flipA || strobes.flipB) |=> $stable(stateQ));

  // R7: error flag follows an accepted illegal code by one cycle
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst)
    strobes.badCode |=> badSym);
  a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
    !strobes.badCode |=> !badSym);

  // R2: decoder raises at most one strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.flipA, strobes.flipB, strobes.badCode}));
endmodule

// File: rtl/sym_parity_tracker.sv
module sym_parity_tracker
  import sym_parity_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] symIn,
  input  logic             symValid,
  output logic             matchOut,
  output logic             badSym
);
  strobe_t strobes;

  parity_ctrl i_ctrl (
    .symIn    (symIn),
    .symValid (symValid),
    .strobes  (strobes)
  );

  parity_state i_state (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .matchOut (matchOut),
    .badSym   (badSym)
  );
endmodule

// File: tb/test_sym_parity_tracker.sv
module test_sym_parity_tracker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] symIn = 2'b00;
  logic       symValid = 1'b0;
  logic       matchOut;
  logic       badSym;

  int checks = 0;
  int errors = 0;
  int aCount = 0;
  int bCount = 0;
  bit expBad = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sym_parity_tracker i_sym_parity_tracker (
    .clk      (clk),
    .rst      (rst),
    .symIn    (symIn),
    .symValid (symValid),
    .matchOut (matchOut),
    .badSym   (badSym)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // Drive one cycle, update the model at the edge, compare after it
  task automatic step(input logic r, input logic v, input logic [1:0] s, input string req);
    @(negedge clk);
    rst = r; symValid = v; symIn = s;
    @(posedge clk);
    if (r) begin
      aCount = 0; bCount = 0; expBad = 1'b0;
    end else begin
      expBad = v && (s == 2'b11);
      if (v && s == 2'b00) aCount++;
      if (v && s == 2'b01) bCount++;
    end
    #1;
    check({req, " matchOut"}, matchOut, (aCount % 2 == 0) && (bCount % 2 == 1));
    check({req, " badSym"}, badSym, expBad);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1, 0, 2'b00, "R1");
    step(1, 1, 2'b11, "R1");
    step(0, 1, 2'b01, "R4 b to odd");
    step(0, 1, 2'b10, "R5 c hold");
    step(0, 0, 2'b00, "R6 idle a");
    step(0, 0, 2'b01, "R6 idle b");
    step(0, 1, 2'b00, "R3 a to odd");
    step(0, 1, 2'b00, "R3 a back even");
    step(0, 1, 2'b11, "R7 bad hold");
    step(0, 1, 2'b11, "R7 bad again");
    step(0, 1, 2'b10, "R7 pulse ends");
    step(0, 0, 2'b11, "R6 idle bad");
    step(0, 1, 2'b01, "R8 b to even");
    step(0, 1, 2'b01, "R8 b to odd");
    step(1, 1, 2'b00, "R9 reset over a");
    step(0, 1, 2'b01, "R2 b code");
    step(1, 1, 2'b01, "R9 reset over b");
    step(0, 1, 2'b11, "R7 bad after reset");
    step(1, 1, 2'b11, "R9 reset over bad");
    for (int i = 0; i < 4000; i++) begin
      logic r;
      r = ($urandom_range(0, 99) == 0);
      step(r, ($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)), "R8 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule